// File: doc/BRIEF.md
# In-Order Issue Scoreboard

This block is the issue-stage hazard checker of an in-order pipeline that feeds four functional units of different latency: integer, add, multiply and divide. One decoded instruction at a time is offered on a ready/valid port. It carries a unit class, a destination register and two source registers. The block compares the instruction against a per-unit occupancy vector and a per-register pending-write vector. It then either dispatches the instruction on that cycle or holds it by keeping `inReady` low, which back-pressures decode.

Every unit is modelled by a latency counter that holds the destination of the operation in flight. When the counter expires, the block drives that destination on a single write-back port and clears the matching pending-write bit. Source operands are taken to be latched by the unit at dispatch, so only pending writes are tracked. No source list is kept and write-after-read never stalls.

Top module: `issue_scoreboard`

## Requirements
- R1: After reset no unit is occupied, no register has a pending write and `wbValid` is low, so an instruction offered first is accepted with `inReady` high.
- R2: Unit codes are 0 integer, 1 add, 2 multiply, 3 divide. An instruction is held while its unit still has an operation with more than one cycle left. A unit whose operation writes back in the current cycle counts as free, so a second divide is accepted in the fourth cycle after the first.
- R3: An instruction is held while either of its source registers has a pending write (read-after-write).
- R4: An instruction is held while its destination register has a pending write (write-after-write). A register therefore has at most one write in flight.
- R5: A pending read of a register by an earlier in-flight instruction never holds a later writer of that register.
- R6: An operation accepted at a clock edge writes back in the cycle that ends at edge plus L, where L is 1 for integer, 1 for add, 3 for multiply and 4 for divide. `wbDest` carries its destination and `wbUnit` carries its unit code.
- R7: An instruction is held if its write-back cycle would equal that of any operation already in flight.
- R8: In the cycle a register is written back, its pending bit already reads as clear for the hazard checks, so a waiting reader or writer of it is accepted in that same cycle.
- R9: An instruction is dispatched exactly when `inValid` and `inReady` are both high. A cycle with `inValid` low marks no register pending and occupies no unit.
- R10: At most one write-back takes place per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Decoded instruction offered |
| inReady | output | 1 | Instruction may dispatch this cycle |
| inUnit | input | 2 | Unit class: 0 integer, 1 add, 2 multiply, 3 divide |
| inDest | input | 5 | Destination register |
| inSrc1 | input | 5 | First source register |
| inSrc2 | input | 5 | Second source register |
| wbValid | output | 1 | A write-back takes place this cycle |
| wbUnit | output | 2 | Unit that is writing back |
| wbDest | output | 5 | Register being written back |

## Verification
A stale pending bit shows at `inReady` as a reader or writer of that register that is never accepted, or one accepted too early. This is seen on the first cycle such an instruction is offered. A counter that is off by one moves `wbValid` by a cycle against the latency in R6. It also shifts the cycles that R7 and R8 accept or hold, so it is visible by the write-back of the first operation on that unit. The reference model predicts `inReady`, `wbValid` and `wbDest` on every cycle, so a divergence is reported on the cycle it first appears. This holds both during directed hazard sequences and during a long run of random traffic over a small register window.

// File: rtl/sb_pkg.sv
package sb_pkg;

  localparam int NUM_REGS  = 32;
  localparam int REG_W     = $clog2(NUM_REGS);
  localparam int NUM_UNITS = 4;
  localparam int UNIT_W    = $clog2(NUM_UNITS);
  localparam int LAT_INT   = 1;
  localparam int LAT_ADD   = 1;
  localparam int LAT_MUL   = 3;
  localparam int LAT_DIV   = 4;
  localparam int MAX_LAT   = 4;
  // counter must also hold MAX_LAT + 1 for the completion comparison
  localparam int CNT_W     = $clog2(MAX_LAT + 2);

  localparam int LAT_TABLE [NUM_UNITS] = '{LAT_INT, LAT_ADD, LAT_MUL, LAT_DIV};

  typedef enum logic [UNIT_W-1:0] {
    UNIT_INT = 2'd0,
    UNIT_ADD = 2'd1,
    UNIT_MUL = 2'd2,
    UNIT_DIV = 2'd3
  } unit_e;

  // strobes from control to datapath
  typedef struct packed {
    logic                 fire;
    logic [NUM_UNITS-1:0] unitSel;
    logic [REG_W-1:0]     dest;
  } sb_strobe_t;

endpackage

// File: rtl/sb_unit_tracker.sv
module sb_unit_tracker
  import sb_pkg::*;
#(
  parameter int LATENCY = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [REG_W-1:0] startDest,
  output logic [CNT_W-1:0] remain,
  output logic [REG_W-1:0] dest,
  output logic             busy,
  output logic             finishing
);

  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(LATENCY);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remain <= '0;
      dest   <= '0;
    end else begin
      if (start) begin
        remain <= LOAD_VAL;
        dest   <= startDest;
      end else if (remain != '0) begin
        remain <= remain - 1'b1;
      end
    end
  end

  // an operation in its final cycle frees the unit for the next dispatch
  assign finishing = (remain == CNT_W'(1));
  assign busy      = (remain > CNT_W'(1));

endmodule

// File: rtl/sb_datapath.sv
module sb_datapath
  import sb_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  sb_strobe_t                       strobe,
  output logic [NUM_UNITS-1:0]             busyVec,
  output logic [NUM_UNITS-1:0]             finishVec,
  output logic [NUM_UNITS-1:0][CNT_W-1:0]  remainArr,
  output logic [NUM_REGS-1:0]              pendingRaw,
  output logic [NUM_REGS-1:0]              pendingEff,
  output logic                             wbValid,
  output logic [UNIT_W-1:0]                wbUnit,
  output logic [REG_W-1:0]                 wbDest
);

  logic [NUM_UNITS-1:0][REG_W-1:0] destArr;
  logic [NUM_REGS-1:0]             clearMask;
  logic [NUM_REGS-1:0]             setMask;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : gUnit
    sb_unit_tracker #(
      .LATENCY (LAT_TABLE[u])
    ) tracker (
      .clk       (clk),
      .rstN      (rstN),
      .start     (strobe.unitSel[u]),
      .startDest (strobe.dest),
      .remain    (remainArr[u]),
      .dest      (destArr[u]),
      .busy      (busyVec[u]),
      .finishing (finishVec[u])
    );
  end

  // single write-back port: select the finishing unit
  always_comb begin
    wbValid = 1'b0;
    wbUnit  = '0;
    wbDest  = '0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (finishVec[u]) begin
        wbValid = 1'b1;
        wbUnit  = UNIT_W'(u);
        wbDest  = destArr[u];
      end
    end
  end

  always_comb begin
    clearMask = '0;
    setMask   = '0;
    if (wbValid)     clearMask[wbDest]      = 1'b1;
    if (strobe.fire) setMask[strobe.dest]   = 1'b1;
  end

  // clear is visible to this cycle's hazard checks
  assign pendingEff = pendingRaw & ~clearMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendingRaw <= '0;
    end else begin
      pendingRaw <= (pendingRaw & ~clearMask) | setMask;
    end
  end

endmodule

// File: rtl/sb_control.sv
module sb_control
  import sb_pkg::*;
(
  input  logic                             inValid,
  input  logic [UNIT_W-1:0]                inUnit,
  input  logic [REG_W-1:0]                 inDest,
  input  logic [REG_W-1:0]                 inSrc1,
  input  logic [REG_W-1:0]                 inSrc2,
  input  logic [NUM_UNITS-1:0]             busyVec,
  input  logic [NUM_UNITS-1:0][CNT_W-1:0]  remainArr,
  input  logic [NUM_REGS-1:0]              pendingEff,
  output logic                             inReady,
  output sb_strobe_t                       strobe
);

  logic [CNT_W-1:0] newDone;
  logic             structHaz;
  logic             rawHaz;
  logic             wawHaz;
  logic             portHaz;

  // cycle count until the new op's write-back, as seen in the remain counters
  always_comb begin
    newDone = CNT_W'(LAT_TABLE[inUnit] + 1);
  end

  always_comb begin
    portHaz = 1'b0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (remainArr[u] == newDone) portHaz = 1'b1;
    end
  end

  assign structHaz = busyVec[inUnit];
  assign rawHaz    = pendingEff[inSrc1] | pendingEff[inSrc2];
  assign wawHaz    = pendingEff[inDest];
  assign inReady   = !(structHaz | rawHaz | wawHaz | portHaz);

  always_comb begin
    strobe.fire    = inValid && inReady;
    strobe.unitSel = '0;
    if (strobe.fire) strobe.unitSel[inUnit] = 1'b1;
    strobe.dest    = inDest;
  end

endmodule

// File: rtl/issue_scoreboard.sv
module issue_scoreboard
  import sb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [UNIT_W-1:0] inUnit,
  input  logic [REG_W-1:0]  inDest,
  input  logic [REG_W-1:0]  inSrc1,
  input  logic [REG_W-1:0]  inSrc2,
  output logic              wbValid,
  output logic [UNIT_W-1:0] wbUnit,
  output logic [REG_W-1:0]  wbDest
);

  sb_strobe_t                      strobe;
  logic [NUM_UNITS-1:0]            busyVec;
  logic [NUM_UNITS-1:0]            finishVec;
  logic [NUM_UNITS-1:0][CNT_W-1:0] remainArr;
  logic [NUM_REGS-1:0]             pendingRaw;
  logic [NUM_REGS-1:0]             pendingEff;

  sb_control ctrl (
    .inValid    (inValid),
    .inUnit     (inUnit),
    .inDest     (inDest),
    .inSrc1     (inSrc1),
    .inSrc2     (inSrc2),
    .busyVec    (busyVec),
    .remainArr  (remainArr),
    .pendingEff (pendingEff),
    .inReady    (inReady),
    .strobe     (strobe)
  );

  sb_datapath dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .busyVec    (busyVec),
    .finishVec  (finishVec),
    .remainArr  (remainArr),
    .pendingRaw (pendingRaw),
    .pendingEff (pendingEff),
    .wbValid    (wbValid),
    .wbUnit     (wbUnit),
    .wbDest     (wbDest)
  );

endmodule

// File: rtl/sb_checker.sv
module sb_checker
  import sb_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 inValid,
  input logic                 inReady,
  input logic [UNIT_W-1:0]    inUnit,
  input logic [REG_W-1:0]     inDest,
  input logic [REG_W-1:0]     inSrc1,
  input logic [REG_W-1:0]     inSrc2,
  input logic                 wbValid,
  input logic [REG_W-1:0]     wbDest,
  input logic [NUM_UNITS-1:0] busyVec,
  input logic [NUM_UNITS-1:0] finishVec,
  input logic [NUM_REGS-1:0]  pendingRaw,
  input logic [NUM_REGS-1:0]  pendingEff
);

  AST_ONE_WB: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(finishVec)); // R10

  AST_STRUCT_FREE: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |-> !busyVec[inUnit]); // R2

  AST_RAW_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |-> (!pendingEff[inSrc1] && !pendingEff[inSrc2])); // R3

  AST_WAW_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |-> !pendingEff[inDest]); // R4

  AST_PEND_SET: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> pendingRaw[$past(inDest)]); // R4

  AST_WB_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> pendingRaw[wbDest]); // R6

  AST_SHORT_LAT: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && (inUnit == UNIT_INT || inUnit == UNIT_ADD))
      |=> (wbValid && wbDest == $past(inDest))); // R6

endmodule

bind issue_scoreboard sb_checker chk (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .inReady    (inReady),
  .inUnit     (inUnit),
  .inDest     (inDest),
  .inSrc1     (inSrc1),
  .inSrc2     (inSrc2),
  .wbValid    (wbValid),
  .wbDest     (wbDest),
  .busyVec    (busyVec),
  .finishVec  (finishVec),
  .pendingRaw (pendingRaw),
  .pendingEff (pendingEff)
);

// File: tb/tb_issue_scoreboard.sv
`timescale 1ns/1ps
module tb_issue_scoreboard;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic       inReady;
  logic [1:0] inUnit = 2'd0;
  logic [4:0] inDest = 5'd0;
  logic [4:0] inSrc1 = 5'd0;
  logic [4:0] inSrc2 = 5'd0;
  logic       wbValid;
  logic [1:0] wbUnit;
  logic [4:0] wbDest;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  issue_scoreboard dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inUnit(inUnit), .inDest(inDest), .inSrc1(inSrc1), .inSrc2(inSrc2),
    .wbValid(wbValid), .wbUnit(wbUnit), .wbDest(wbDest)
  );

  // ---------------- behavioural reference model ----------------
  typedef struct { int unit; int dest; longint doneEdge; } flight_t;
  flight_t inFlight[$];
  longint edgeCount = 0;

  function automatic int latOf(int u);
    case (u)
      0: return 1;
      1: return 1;
      2: return 3;
      default: return 4;
    endcase
  endfunction

  function automatic bit regPending(int r);
    foreach (inFlight[i])
      if (inFlight[i].dest == r && inFlight[i].doneEdge > edgeCount + 1) return 1;
    return 0;
  endfunction

  function automatic bit modelReady();
    int u;
    u = int'(inUnit);
    foreach (inFlight[i]) begin
      if (inFlight[i].unit == u && inFlight[i].doneEdge > edgeCount + 1) return 0;
      if (inFlight[i].doneEdge == edgeCount + 1 + latOf(u)) return 0;
    end
    if (regPending(int'(inSrc1)) || regPending(int'(inSrc2)) || regPending(int'(inDest)))
      return 0;
    return 1;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      inFlight.delete();
    end else begin
      bit fire;
      fire = inValid && modelReady();
      for (int i = inFlight.size() - 1; i >= 0; i--)
        if (inFlight[i].doneEdge == edgeCount + 1) inFlight.delete(i);
      if (fire)
        inFlight.push_back('{int'(inUnit), int'(inDest), edgeCount + 1 + latOf(int'(inUnit))});
    end
    edgeCount++;
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (rstN && !done) begin
      bit expWb;
      int expDest;
      expWb = 0;
      expDest = 0;
      foreach (inFlight[i])
        if (inFlight[i].doneEdge == edgeCount + 1) begin
          expWb = 1;
          expDest = inFlight[i].dest;
        end
      check("R9 model inReady", int'(inReady), int'(modelReady()));
      check("R6/R10 model wbValid", int'(wbValid), int'(expWb));
      if (expWb) check("R6 model wbDest", int'(wbDest), expDest);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic drive(bit v, int u, int d, int s1, int s2);
    @(negedge clk);
    inValid = v;
    inUnit  = 2'(u);
    inDest  = 5'(d);
    inSrc1  = 5'(s1);
    inSrc2  = 5'(s2);
    #1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0);
  endtask

  task automatic latencyTest(int u, int d, int lat);
    drive(1, u, d, 30, 31);
    check("R6 accept", int'(inReady), 1);
    for (int k = 1; k <= lat; k++) begin
      drive(0, 0, 0, 0, 0);
      check("R6 wbValid timing", int'(wbValid), (k == lat) ? 1 : 0);
      if (k == lat) begin
        check("R6 wbDest", int'(wbDest), d);
        check("R6 wbUnit", int'(wbUnit), u);
      end
    end
    idle(2);
  endtask

  task automatic finish();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: clean state after reset
    drive(0, 0, 0, 0, 0);
    check("R1 inReady after reset", int'(inReady), 1);
    check("R1 wbValid after reset", int'(wbValid), 0);

    // R6: per-unit latency
    latencyTest(0, 1, 1);
    latencyTest(1, 2, 1);
    latencyTest(2, 3, 3);
    latencyTest(3, 4, 4);

    // R2: unpipelined divider
    drive(1, 3, 1, 20, 21);
    check("R2 first divide", int'(inReady), 1);
    for (int k = 1; k <= 3; k++) begin
      drive(1, 3, 2, 22, 23);
      check("R2 divider busy", int'(inReady), 0);
    end
    drive(1, 3, 2, 22, 23);
    check("R2 divider free in finishing cycle", int'(inReady), 1);
    idle(6);

    // R3 then R8: reader waits for multiply result
    drive(1, 2, 5, 1, 1);
    check("R3 producer", int'(inReady), 1);
    drive(1, 1, 7, 5, 0);
    check("R3 reader held", int'(inReady), 0);
    drive(1, 1, 7, 5, 0);
    check("R3 reader held", int'(inReady), 0);
    drive(1, 1, 7, 5, 0);
    check("R8 reader accepted in write-back cycle", int'(inReady), 1);
    check("R8 wbValid", int'(wbValid), 1);
    check("R8 wbDest", int'(wbDest), 5);
    idle(4);

    // R4: second writer of same register
    drive(1, 3, 9, 1, 2);
    check("R4 first writer", int'(inReady), 1);
    for (int k = 1; k <= 3; k++) begin
      drive(1, 0, 9, 3, 4);
      check("R4 second writer held", int'(inReady), 0);
    end
    drive(1, 0, 9, 3, 4);
    check("R4 second writer accepted after clear", int'(inReady), 1);
    drive(0, 0, 0, 0, 0);
    check("R4 second write-back", int'(wbValid), 1);
    check("R4 second write-back dest", int'(wbDest), 9);
    idle(3);

    // R7: write-back port collision
    drive(1, 2, 10, 1, 2);
    check("R7 multiply", int'(inReady), 1);
    drive(0, 0, 0, 0, 0);
    drive(1, 0, 11, 12, 13);
    check("R7 integer held on same write-back cycle", int'(inReady), 0);
    drive(1, 0, 11, 12, 13);
    check("R7 integer accepted next cycle", int'(inReady), 1);
    idle(4);

    // R5: writer of a register an in-flight op reads
    drive(1, 3, 3, 4, 4);
    check("R5 divide reading r4", int'(inReady), 1);
    drive(1, 0, 4, 1, 2);
    check("R5 writer of r4 not held", int'(inReady), 1);
    drive(0, 0, 0, 0, 0);
    check("R5 write-back of r4", int'(wbValid), 1);
    check("R5 write-back dest", int'(wbDest), 4);
    idle(6);

    // R9: invalid cycles leave no trace
    for (int k = 0; k < 3; k++) begin
      drive(0, 3, 14, 0, 0);
      check("R9 no write-back from invalid", int'(wbValid), 0);
    end
    drive(1, 0, 15, 14, 14);
    check("R9 r14 not pending", int'(inReady), 1);
    idle(3);

    // random traffic over a small register window
    for (int k = 0; k < 3000; k++)
      drive(($urandom % 10) < 7, $urandom % 4, $urandom % 8, $urandom % 8, $urandom % 8);
    idle(8);

    finish();
  end

endmodule